// File: doc/BRIEF.md
# Scaler Filter Tap Selector

This block settles, for every new scaler configuration, how many filter taps each of the four filter paths uses. The paths are luma horizontal, luma vertical, chroma horizontal and chroma vertical. It takes the requested tap count and the scaling ratio of each path, with the ratio in unsigned fixed point with `FRAC_W` fractional bits. It returns the tap count each path will actually run with and the ratio to program. A single accept flag tells whether the configuration can be scaled at all.

Along with the per-path data it takes three flags: the source pixels are half-float, the scaler handles fixed point only, and identity shortcuts are disabled. It also takes three widths: the source viewport width, the active output width and an optional ceiling on source width when downscaling. A configuration is presented with `in_valid`. One clock later the registered decision appears with an `out_valid` pulse. Each path handles at most eight taps.

Top module: `scl_tap_sel`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. All decision outputs are registered, and they keep their values while `in_valid` is low. After reset, `out_valid`, `out_accept`, every tap output and every ratio output are 0.
- R2: A requested tap count above 8 is treated as 8 before any other tap rule is applied.
- R3: A requested tap count of 0 becomes 4 on the two luma paths and 2 on the two chroma paths.
- R4: On the chroma horizontal path an odd count other than 1 is lowered by one, so that path only runs 1 or an even number of taps. The other paths keep odd counts.
- R5: A ratio equal to exactly 4.0 (value 4·2^32 with 32 fractional bits) is output one LSB lower. Every other ratio of an accepted configuration is output unchanged.
- R6: When `always_scale` is low, a path uses 1 tap if its output ratio, cut down to its two lowest integer bits and its 19 highest fractional bits, equals 2^19. So 1.0 plus 1 LSB counts as identity, while 1.0 plus 2^-19 does not.
- R7: When `always_scale` is high, the identity rule of R6 is not applied.
- R8: The configuration is rejected when `src_half_float` and `fixed_only` are both high and both luma ratios differ from exactly 1.0. If either luma ratio is exactly 1.0, or either flag is low, the configuration is accepted.
- R9: The configuration is rejected when `vp_width` exceeds `active_width`, `max_ds_width` is nonzero, and `vp_width` exceeds `max_ds_width`.
- R10: On a rejected configuration `out_accept` is 0, all four tap outputs are 0, and the ratio outputs carry the input ratios unmodified (no 4.0 clamp).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | New configuration present |
| req_taps_lh | input | REQ_W | Requested taps, luma horizontal |
| req_taps_lv | input | REQ_W | Requested taps, luma vertical |
| req_taps_ch | input | REQ_W | Requested taps, chroma horizontal |
| req_taps_cv | input | REQ_W | Requested taps, chroma vertical |
| ratio_lh | input | INT_W+FRAC_W | Ratio, luma horizontal |
| ratio_lv | input | INT_W+FRAC_W | Ratio, luma vertical |
| ratio_ch | input | INT_W+FRAC_W | Ratio, chroma horizontal |
| ratio_cv | input | INT_W+FRAC_W | Ratio, chroma vertical |
| src_half_float | input | 1 | Source pixels are half-float |
| fixed_only | input | 1 | Scaler processes fixed point only |
| always_scale | input | 1 | Disable identity single-tap shortcut |
| vp_width | input | WIDTH_W | Source viewport width |
| active_width | input | WIDTH_W | Active output width |
| max_ds_width | input | WIDTH_W | Downscale source width ceiling, 0 = none |
| out_valid | output | 1 | Decision valid pulse |
| out_accept | output | 1 | Configuration supported |
| taps_lh | output | TAP_W | Effective taps, luma horizontal |
| taps_lv | output | TAP_W | Effective taps, luma vertical |
| taps_ch | output | TAP_W | Effective taps, chroma horizontal |
| taps_cv | output | TAP_W | Effective taps, chroma vertical |
| out_ratio_lh | output | INT_W+FRAC_W | Programmed ratio, luma horizontal |
| out_ratio_lv | output | INT_W+FRAC_W | Programmed ratio, luma vertical |
| out_ratio_ch | output | INT_W+FRAC_W | Programmed ratio, chroma horizontal |
| out_ratio_cv | output | INT_W+FRAC_W | Programmed ratio, chroma vertical |

## Verification
Tap selection is tried with four kinds of requests. All-zero requests separate the luma and chroma defaults. Over-range requests show that saturation happens before the evenness rule. Odd requests show that only the chroma horizontal path is made even and that a request of one is left alone. Ratios of exactly 1.0, 1.0 plus one LSB and 1.0 plus 2^-19, each with and without the override, locate the identity boundary, and a ratio of exactly 4.0 shows that the clamped value is not mistaken for identity. Reject patterns switch on one condition of each rule at a time, so that a rule firing on a partial match is caught. The widths sit either side of each comparison.

// File: rtl/scl_tap_pkg.sv
// Package: shared constants and per-path properties for the tap selector.
// Assumes four filter paths in a fixed order used for generate indexing.
package scl_tap_pkg;

    localparam int NUM_PATHS = 4;

    typedef enum logic [1:0] {
        PATH_LUMA_H   = 2'd0,
        PATH_LUMA_V   = 2'd1,
        PATH_CHROMA_H = 2'd2,
        PATH_CHROMA_V = 2'd3
    } path_e;

    // Default tap count applied when the request is zero
    function automatic int default_taps(input int path);
        return (path == int'(PATH_LUMA_H) || path == int'(PATH_LUMA_V)) ? 4 : 2;
    endfunction

    // Whether a path only runs 1 or an even number of taps
    function automatic bit even_only(input int path);
        return path == int'(PATH_CHROMA_H);
    endfunction

endpackage

// File: rtl/scl_tap_path.sv
// Module: per-path tap and ratio resolution, purely combinational.
// Order: saturate request, substitute default, enforce evenness (if the
// path requires it), clamp a 4.0 ratio, then apply the identity shortcut
// to the clamped ratio. Assumes FRAC_W >= 19 and INT_W >= 3.
module scl_tap_path #(
    parameter int PATH     = 0,
    parameter int REQ_W    = 4,
    parameter int MAX_TAPS = 8,
    parameter int INT_W    = 3,
    parameter int FRAC_W   = 32,
    localparam int TAP_W   = $clog2(MAX_TAPS + 1),
    localparam int RATIO_W = INT_W + FRAC_W
) (
    input  logic [REQ_W-1:0]   req_taps,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               always_scale,
    output logic [TAP_W-1:0]   taps,
    output logic [RATIO_W-1:0] ratio_adj
);
    import scl_tap_pkg::*;

    localparam int                 ID_FRAC  = 19;
    localparam int                 ID_W     = 2 + ID_FRAC;
    localparam int                 ID_LSB   = FRAC_W - ID_FRAC;
    localparam logic [ID_W-1:0]    ID_ONE   = ID_W'(1) << ID_FRAC;
    localparam logic [RATIO_W-1:0] FOUR_R   = RATIO_W'(4) << FRAC_W;
    localparam logic [TAP_W-1:0]   DEF_T    = TAP_W'(default_taps(PATH));
    localparam logic [TAP_W-1:0]   MAX_T    = TAP_W'(MAX_TAPS);
    localparam bit                 EVEN_REQ = even_only(PATH);

    logic [TAP_W-1:0] sat_taps;
    logic [TAP_W-1:0] dflt_taps;
    logic [TAP_W-1:0] even_taps;
    logic [ID_W-1:0]  id_field;
    logic             is_identity;

    // Saturate an over-range request to the path maximum
    always_comb begin
        if (req_taps > REQ_W'(MAX_TAPS)) sat_taps = MAX_T;
        else                             sat_taps = TAP_W'(req_taps);
    end

    // Substitute the per-path default for a zero request
    always_comb begin
        dflt_taps = (sat_taps == '0) ? DEF_T : sat_taps;
    end

    // Evenness rule: one of two variants picked by the path
    generate
        if (EVEN_REQ) begin : g_even
            always_comb begin
                if (dflt_taps[0] && dflt_taps != TAP_W'(1))
                    even_taps = dflt_taps - TAP_W'(1);
                else
                    even_taps = dflt_taps;
            end
        end else begin : g_any
            always_comb begin
                even_taps = dflt_taps;
            end
        end
    endgenerate

    // Clamp an exact 4.0 ratio to one LSB below
    always_comb begin
        ratio_adj = (ratio == FOUR_R) ? (ratio - RATIO_W'(1)) : ratio;
    end

    // Identity test on the truncated 2.19 view of the clamped ratio
    always_comb begin
        id_field    = ratio_adj[ID_LSB +: ID_W];
        is_identity = (id_field == ID_ONE) && !always_scale;
        taps        = is_identity ? TAP_W'(1) : even_taps;
    end

endmodule

// File: rtl/scl_tap_gate.sv
// Module: accept/reject decision for a scaler configuration.
// Rejects half-float input on fixed-only hardware when both luma ratios
// scale, and oversized downscale sources when a ceiling is configured.
module scl_tap_gate #(
    parameter int INT_W    = 3,
    parameter int FRAC_W   = 32,
    parameter int WIDTH_W  = 14,
    localparam int RATIO_W = INT_W + FRAC_W
) (
    input  logic               src_half_float,
    input  logic               fixed_only,
    input  logic [RATIO_W-1:0] ratio_h,
    input  logic [RATIO_W-1:0] ratio_v,
    input  logic [WIDTH_W-1:0] vp_width,
    input  logic [WIDTH_W-1:0] active_width,
    input  logic [WIDTH_W-1:0] max_ds_width,
    output logic               accept
);
    localparam logic [RATIO_W-1:0] ONE_R = RATIO_W'(1) << FRAC_W;

    logic fmt_reject;
    logic width_reject;

    // Half-float on fixed-point-only hardware with scaling in both axes
    always_comb begin
        fmt_reject = src_half_float && fixed_only &&
                     (ratio_h != ONE_R) && (ratio_v != ONE_R);
    end

    // Downscale source wider than the configured ceiling
    always_comb begin
        width_reject = (vp_width > active_width) && (max_ds_width != '0) &&
                       (vp_width > max_ds_width);
    end

    // Combined verdict
    always_comb begin
        accept = !(fmt_reject || width_reject);
    end

endmodule

// File: rtl/scl_tap_sel.sv
// Module: top of the scaler tap selector. Resolves four paths in parallel,
// gates them with the accept decision and registers the result one cycle
// after in_valid. Assumes in_valid inputs are stable in their cycle.
module scl_tap_sel #(
    parameter int REQ_W    = 4,
    parameter int MAX_TAPS = 8,
    parameter int INT_W    = 3,
    parameter int FRAC_W   = 32,
    parameter int WIDTH_W  = 14,
    localparam int TAP_W   = $clog2(MAX_TAPS + 1),
    localparam int RATIO_W = INT_W + FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [REQ_W-1:0]   req_taps_lh,
    input  logic [REQ_W-1:0]   req_taps_lv,
    input  logic [REQ_W-1:0]   req_taps_ch,
    input  logic [REQ_W-1:0]   req_taps_cv,
    input  logic [RATIO_W-1:0] ratio_lh,
    input  logic [RATIO_W-1:0] ratio_lv,
    input  logic [RATIO_W-1:0] ratio_ch,
    input  logic [RATIO_W-1:0] ratio_cv,
    input  logic               src_half_float,
    input  logic               fixed_only,
    input  logic               always_scale,
    input  logic [WIDTH_W-1:0] vp_width,
    input  logic [WIDTH_W-1:0] active_width,
    input  logic [WIDTH_W-1:0] max_ds_width,
    output logic               out_valid,
    output logic               out_accept,
    output logic [TAP_W-1:0]   taps_lh,
    output logic [TAP_W-1:0]   taps_lv,
    output logic [TAP_W-1:0]   taps_ch,
    output logic [TAP_W-1:0]   taps_cv,
    output logic [RATIO_W-1:0] out_ratio_lh,
    output logic [RATIO_W-1:0] out_ratio_lv,
    output logic [RATIO_W-1:0] out_ratio_ch,
    output logic [RATIO_W-1:0] out_ratio_cv
);
    import scl_tap_pkg::*;

    logic [REQ_W-1:0]   req_a   [NUM_PATHS];
    logic [RATIO_W-1:0] ratio_a [NUM_PATHS];
    logic [TAP_W-1:0]   taps_a  [NUM_PATHS];
    logic [RATIO_W-1:0] adj_a   [NUM_PATHS];
    logic [TAP_W-1:0]   taps_q  [NUM_PATHS];
    logic [RATIO_W-1:0] ratio_q [NUM_PATHS];
    logic               accept_c;
    logic               valid_q;
    logic               accept_q;

    // Gather per-path inputs into arrays in path order
    always_comb begin
        req_a[PATH_LUMA_H]     = req_taps_lh;
        req_a[PATH_LUMA_V]     = req_taps_lv;
        req_a[PATH_CHROMA_H]   = req_taps_ch;
        req_a[PATH_CHROMA_V]   = req_taps_cv;
        ratio_a[PATH_LUMA_H]   = ratio_lh;
        ratio_a[PATH_LUMA_V]   = ratio_lv;
        ratio_a[PATH_CHROMA_H] = ratio_ch;
        ratio_a[PATH_CHROMA_V] = ratio_cv;
    end

    generate
        for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
            scl_tap_path #(
                .PATH     (p),
                .REQ_W    (REQ_W),
                .MAX_TAPS (MAX_TAPS),
                .INT_W    (INT_W),
                .FRAC_W   (FRAC_W)
            ) path_i (
                .req_taps     (req_a[p]),
                .ratio        (ratio_a[p]),
                .always_scale (always_scale),
                .taps         (taps_a[p]),
                .ratio_adj    (adj_a[p])
            );

            // Capture this path's decision; rejected configs zero taps
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    taps_q[p]  <= '0;
                    ratio_q[p] <= '0;
                end else if (in_valid) begin
                    taps_q[p]  <= accept_c ? taps_a[p] : '0;
                    ratio_q[p] <= accept_c ? adj_a[p] : ratio_a[p];
                end
            end
        end
    endgenerate

    scl_tap_gate #(
        .INT_W   (INT_W),
        .FRAC_W  (FRAC_W),
        .WIDTH_W (WIDTH_W)
    ) gate_i (
        .src_half_float (src_half_float),
        .fixed_only     (fixed_only),
        .ratio_h        (ratio_lh),
        .ratio_v        (ratio_lv),
        .vp_width       (vp_width),
        .active_width   (active_width),
        .max_ds_width   (max_ds_width),
        .accept         (accept_c)
    );

    // Valid pulse and registered verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) accept_q <= accept_c;
        end
    end

    // Drive the ports from the registered state
    always_comb begin
        out_valid    = valid_q;
        out_accept   = accept_q;
        taps_lh      = taps_q[PATH_LUMA_H];
        taps_lv      = taps_q[PATH_LUMA_V];
        taps_ch      = taps_q[PATH_CHROMA_H];
        taps_cv      = taps_q[PATH_CHROMA_V];
        out_ratio_lh = ratio_q[PATH_LUMA_H];
        out_ratio_lv = ratio_q[PATH_LUMA_V];
        out_ratio_ch = ratio_q[PATH_CHROMA_H];
        out_ratio_cv = ratio_q[PATH_CHROMA_V];
    end

endmodule

// File: rtl/scl_tap_sel_chk.sv
// Module: protocol and range checks on the tap selector ports, bound in.
module scl_tap_sel_chk #(
    parameter int MAX_TAPS = 8,
    parameter int INT_W    = 3,
    parameter int FRAC_W   = 32,
    localparam int TAP_W   = $clog2(MAX_TAPS + 1),
    localparam int RATIO_W = INT_W + FRAC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               out_valid,
    input logic               out_accept,
    input logic [TAP_W-1:0]   taps_lh,
    input logic [TAP_W-1:0]   taps_lv,
    input logic [TAP_W-1:0]   taps_ch,
    input logic [TAP_W-1:0]   taps_cv,
    input logic [RATIO_W-1:0] out_ratio_lh,
    input logic [RATIO_W-1:0] out_ratio_lv,
    input logic [RATIO_W-1:0] out_ratio_ch,
    input logic [RATIO_W-1:0] out_ratio_cv
);
    localparam logic [RATIO_W-1:0] FOUR_R = RATIO_W'(4) << FRAC_W;
    localparam logic [TAP_W-1:0]   MAX_T  = TAP_W'(MAX_TAPS);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(taps_lh) && $stable(out_ratio_cv) && $stable(out_accept))); // R1
    AST_TAPS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_accept) |-> (taps_lh != '0 && taps_lv != '0 && taps_ch != '0 &&
        taps_cv != '0 && taps_lh <= MAX_T && taps_lv <= MAX_T && taps_ch <= MAX_T &&
        taps_cv <= MAX_T)); // R2
    AST_CHROMA_H_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_accept) |-> (taps_ch == TAP_W'(1) || !taps_ch[0])); // R4
    AST_NO_FOUR_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_accept) |-> (out_ratio_lh != FOUR_R && out_ratio_lv != FOUR_R &&
        out_ratio_ch != FOUR_R && out_ratio_cv != FOUR_R)); // R5
    AST_REJECT_ZERO_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_accept) |-> (taps_lh == '0 && taps_lv == '0 &&
        taps_ch == '0 && taps_cv == '0)); // R10

endmodule

bind scl_tap_sel scl_tap_sel_chk #(
    .MAX_TAPS (MAX_TAPS),
    .INT_W    (INT_W),
    .FRAC_W   (FRAC_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_accept   (out_accept),
    .taps_lh      (taps_lh),
    .taps_lv      (taps_lv),
    .taps_ch      (taps_ch),
    .taps_cv      (taps_cv),
    .out_ratio_lh (out_ratio_lh),
    .out_ratio_lv (out_ratio_lv),
    .out_ratio_ch (out_ratio_ch),
    .out_ratio_cv (out_ratio_cv)
);

// File: tb/scl_tap_sel_tb_top.sv
`timescale 1ns/1ps
// Bench: vector table walk, then directed reset, clamp, reject and hold tests.
module scl_tap_sel_tb_top;

    localparam logic [34:0] ONE   = 35'h1_0000_0000;
    localparam logic [34:0] FOUR  = 35'h4_0000_0000;
    localparam logic [34:0] R1P5  = 35'h1_8000_0000;
    localparam logic [34:0] HALF  = 35'h0_8000_0000;
    localparam logic [34:0] TWO   = 35'h2_0000_0000;
    localparam logic [34:0] ONE_T = 35'h1_0000_0001;
    localparam logic [34:0] ONE_S = 35'h1_0000_2000;

    typedef struct packed {
        logic [3:0]  rh, rv, rhc, rvc;
        logic [34:0] qh, qv, qhc, qvc;
        logic        hf, fo, asc;
        logic [13:0] vp, act, mx;
        logic        acc;
        logic [3:0]  th, tv, thc, tvc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        // R3 defaults on zero requests
        '{4'd0, 4'd0, 4'd0, 4'd0, R1P5, R1P5, R1P5, R1P5, 1'b0, 1'b0, 1'b0, 14'd100, 14'd200, 14'd0, 1'b1, 4'd4, 4'd4, 4'd2, 4'd2},
        // R2 saturation
        '{4'd12, 4'd9, 4'd15, 4'd10, R1P5, R1P5, R1P5, R1P5, 1'b0, 1'b0, 1'b0, 14'd100, 14'd200, 14'd0, 1'b1, 4'd8, 4'd8, 4'd8, 4'd8},
        // R4 odd chroma horizontal lowered, others kept
        '{4'd3, 4'd5, 4'd7, 4'd3, HALF, HALF, HALF, HALF, 1'b0, 1'b0, 1'b0, 14'd100, 14'd200, 14'd0, 1'b1, 4'd3, 4'd5, 4'd6, 4'd3},
        // R4 one tap kept on chroma horizontal
        '{4'd6, 4'd6, 4'd1, 4'd5, TWO, TWO, TWO, TWO, 1'b0, 1'b0, 1'b0, 14'd100, 14'd200, 14'd0, 1'b1, 4'd6, 4'd6, 4'd1, 4'd5},
        // R6 identity
        '{4'd6, 4'd6, 4'd4, 4'd4, ONE, ONE, ONE, ONE, 1'b0, 1'b0, 1'b0, 14'd100, 14'd200, 14'd0, 1'b1, 4'd1, 4'd1, 4'd1, 4'd1},
        // R7 always-scale
        '{4'd6, 4'd6, 4'd4, 4'd4, ONE, ONE, ONE, ONE, 1'b0, 1'b0, 1'b1, 14'd100, 14'd200, 14'd0, 1'b1, 4'd6, 4'd6, 4'd4, 4'd4},
        // R6 truncation boundary and R5 clamped four is not identity
        '{4'd5, 4'd5, 4'd4, 4'd4, ONE_T, ONE_S, FOUR, ONE, 1'b0, 1'b0, 1'b0, 14'd100, 14'd200, 14'd0, 1'b1, 4'd1, 4'd5, 4'd4, 4'd1},
        // R8 reject
        '{4'd4, 4'd4, 4'd2, 4'd2, R1P5, R1P5, R1P5, R1P5, 1'b1, 1'b1, 1'b0, 14'd100, 14'd200, 14'd0, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0},
        // R8 one luma ratio at 1.0 accepts
        '{4'd4, 4'd4, 4'd2, 4'd2, ONE, R1P5, R1P5, R1P5, 1'b1, 1'b1, 1'b0, 14'd100, 14'd200, 14'd0, 1'b1, 4'd1, 4'd4, 4'd2, 4'd2},
        // R8 float without fixed-only accepts
        '{4'd0, 4'd0, 4'd0, 4'd0, R1P5, R1P5, R1P5, R1P5, 1'b1, 1'b0, 1'b0, 14'd100, 14'd200, 14'd0, 1'b1, 4'd4, 4'd4, 4'd2, 4'd2},
        // R9 reject
        '{4'd0, 4'd0, 4'd0, 4'd0, R1P5, R1P5, R1P5, R1P5, 1'b0, 1'b0, 1'b0, 14'd300, 14'd200, 14'd250, 1'b0, 4'd0, 4'd0, 4'd0, 4'd0},
        // R9 no ceiling accepts
        '{4'd0, 4'd0, 4'd0, 4'd0, R1P5, R1P5, R1P5, R1P5, 1'b0, 1'b0, 1'b0, 14'd300, 14'd200, 14'd0, 1'b1, 4'd4, 4'd4, 4'd2, 4'd2},
        // R9 under ceiling accepts
        '{4'd0, 4'd0, 4'd0, 4'd0, R1P5, R1P5, R1P5, R1P5, 1'b0, 1'b0, 1'b0, 14'd250, 14'd200, 14'd250, 1'b1, 4'd4, 4'd4, 4'd2, 4'd2},
        // R9 not a downscale accepts
        '{4'd0, 4'd0, 4'd0, 4'd0, R1P5, R1P5, R1P5, R1P5, 1'b0, 1'b0, 1'b0, 14'd180, 14'd200, 14'd150, 1'b1, 4'd4, 4'd4, 4'd2, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  req_taps_lh = '0, req_taps_lv = '0, req_taps_ch = '0, req_taps_cv = '0;
    logic [34:0] ratio_lh = '0, ratio_lv = '0, ratio_ch = '0, ratio_cv = '0;
    logic        src_half_float = 1'b0, fixed_only = 1'b0, always_scale = 1'b0;
    logic [13:0] vp_width = '0, active_width = '0, max_ds_width = '0;
    logic        out_valid, out_accept;
    logic [3:0]  taps_lh, taps_lv, taps_ch, taps_cv;
    logic [34:0] out_ratio_lh, out_ratio_lv, out_ratio_ch, out_ratio_cv;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    scl_tap_sel dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .req_taps_lh(req_taps_lh), .req_taps_lv(req_taps_lv),
        .req_taps_ch(req_taps_ch), .req_taps_cv(req_taps_cv),
        .ratio_lh(ratio_lh), .ratio_lv(ratio_lv), .ratio_ch(ratio_ch), .ratio_cv(ratio_cv),
        .src_half_float(src_half_float), .fixed_only(fixed_only), .always_scale(always_scale),
        .vp_width(vp_width), .active_width(active_width), .max_ds_width(max_ds_width),
        .out_valid(out_valid), .out_accept(out_accept),
        .taps_lh(taps_lh), .taps_lv(taps_lv), .taps_ch(taps_ch), .taps_cv(taps_cv),
        .out_ratio_lh(out_ratio_lh), .out_ratio_lv(out_ratio_lv),
        .out_ratio_ch(out_ratio_ch), .out_ratio_cv(out_ratio_cv)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Present one configuration for a single cycle; return after its result registers
    task automatic apply(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        req_taps_lh = v.rh; req_taps_lv = v.rv; req_taps_ch = v.rhc; req_taps_cv = v.rvc;
        ratio_lh = v.qh; ratio_lv = v.qv; ratio_ch = v.qhc; ratio_cv = v.qvc;
        src_half_float = v.hf; fixed_only = v.fo; always_scale = v.asc;
        vp_width = v.vp; active_width = v.act; max_ds_width = v.mx;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic vec_t mk(input logic [34:0] q, input logic hf, input logic fo);
        vec_t v;
        v = '0;
        v.rh = 4'd4; v.rv = 4'd4; v.rhc = 4'd2; v.rvc = 4'd2;
        v.qh = q; v.qv = q; v.qhc = q; v.qvc = q;
        v.hf = hf; v.fo = fo;
        v.vp = 14'd100; v.act = 14'd200;
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R1 reset accept", 64'(out_accept), 64'd0);
        check("R1 reset taps", 64'({taps_lh, taps_lv, taps_ch, taps_cv}), 64'd0);
        check("R1 reset ratio", 64'(out_ratio_lh | out_ratio_cv), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            check($sformatf("R1 valid vec%0d", i), 64'(out_valid), 64'd1);
            check($sformatf("R8/R9 accept vec%0d", i), 64'(out_accept), 64'(VT[i].acc));
            check($sformatf("R2-R7/R10 taps lh vec%0d", i), 64'(taps_lh), 64'(VT[i].th));
            check($sformatf("R2-R7/R10 taps lv vec%0d", i), 64'(taps_lv), 64'(VT[i].tv));
            check($sformatf("R2-R7/R10 taps ch vec%0d", i), 64'(taps_ch), 64'(VT[i].thc));
            check($sformatf("R2-R7/R10 taps cv vec%0d", i), 64'(taps_cv), 64'(VT[i].tvc));
        end

        // R5 clamp of 4.0 on every path, normal ratio untouched
        apply(mk(FOUR, 1'b0, 1'b0));
        check("R5 lh", 64'(out_ratio_lh), 64'(FOUR - 35'd1));
        check("R5 lv", 64'(out_ratio_lv), 64'(FOUR - 35'd1));
        check("R5 ch", 64'(out_ratio_ch), 64'(FOUR - 35'd1));
        check("R5 cv", 64'(out_ratio_cv), 64'(FOUR - 35'd1));
        check("R5 taps not identity", 64'(taps_lh), 64'd4);
        apply(mk(R1P5, 1'b0, 1'b0));
        check("R5 passthrough", 64'(out_ratio_lv), 64'(R1P5));

        // R10 reject passes raw ratios, no clamp
        apply(mk(FOUR, 1'b1, 1'b1));
        check("R10 accept", 64'(out_accept), 64'd0);
        check("R10 raw ratio lh", 64'(out_ratio_lh), 64'(FOUR));
        check("R10 raw ratio ch", 64'(out_ratio_ch), 64'(FOUR));
        check("R10 taps", 64'({taps_lh, taps_lv, taps_ch, taps_cv}), 64'd0);

        // R1 outputs hold and valid drops while in_valid is low
        apply(mk(R1P5, 1'b0, 1'b0));
        @(negedge clk);
        req_taps_lh = 4'd7; ratio_lh = TWO; vp_width = 14'd300; max_ds_width = 14'd250;
        @(posedge clk);
        #1;
        check("R1 valid low", 64'(out_valid), 64'd0);
        @(posedge clk);
        #1;
        check("R1 hold taps", 64'(taps_lh), 64'd4);
        check("R1 hold ratio", 64'(out_ratio_lh), 64'(R1P5));
        check("R1 hold accept", 64'(out_accept), 64'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule